// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing front end of a three-channel interval timer. A host reaches it over a narrow bus: a 2-bit address, a write strobe with an 8-bit write byte, and a read strobe with an 8-bit read byte. The highest address holds the control port. The lower addresses each reach the counter of one channel. The counters are 16 bits wide, so every count moves across the bus one byte at a time.

A control byte picks a channel and does one of two things. It either sets up that channel (its operating mode, its decimal flag and how its count bytes are sequenced) or freezes a snapshot of its running count for a later two-byte readback. Data writes gather bytes into a 16-bit load command. When a load command is complete, the block raises a one-cycle load pulse together with the value for the counter core. Data reads return bytes of the live count that the counter core supplies, or bytes of the frozen snapshot. Each channel runs its own byte sequencer, so accesses to different channels can be interleaved.

The counting itself sits outside this block. It arrives on `live_cnt` and leaves as `load_pulse`/`load_val`. A load value of zero stands for a full 65536-count period.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, every channel reports mode 3, decimal flag 0 and load value 0x0000 (a full 65536 period), and no load pulse is raised. The gate defaults are high for channels 0 and 1 and low for channel 2. Every channel starts in low-byte-only access.
- R2: A write to address 3 whose bits 7:6 equal 3 changes nothing. Modes, flags, access sequencing and loads on every channel stay as they were.
- R3: A write to address 3 with bits 5:4 not zero configures the channel given by bits 7:6. Bits 3:1 become its mode and bit 0 its decimal flag, both visible after the write edge. Bits 5:4 select the access: 1 means low byte only, 2 means high byte only, 3 means low then high. The byte sequence restarts at its first byte.
- R4: In low-byte-only access, a data write raises load_pulse for that channel for one cycle after the write edge, with load_val = {0x00, byte}.
- R5: In high-byte-only access, a data write loads load_val = {byte, 0x00} with a one-cycle pulse.
- R6: In low-then-high access, the first data write stores the low byte and produces no pulse. The second write loads {second, first} with a one-cycle pulse, and the sequence then returns to the low byte.
- R7: In low-then-high access, successive reads of the channel alternate between the low and the high byte of the live count, starting with the low byte.
- R8: In single-byte access, every read returns the same byte of the live count: the low byte for low-only access and the high byte for high-only access.
- R9: A write to address 3 with bits 5:4 equal to 0 captures the live count of the selected channel at the write edge. The next two reads of that channel return the captured low byte and then the captured high byte, whatever the live count does in between. After that, reads resume the channel's configured access from its first byte.
- R10: While a captured count is pending readback, data writes to that channel are ignored: no load pulse, and the readback sequence is not disturbed.
- R11: The channels sequence independently. An access to one channel never advances or loads another, and at most one channel pulses per cycle.
- R12: read data is combinational and valid in the cycle the read strobe is high. A read of address 3 returns 0x00 and changes no state. If both strobes are high in one cycle, the write takes effect and the read does not advance any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address; 3 is the control port |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; the sequence advances at the clock edge |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| live_cnt | input | 48 | Running count of each channel, channel i at bits 16i+15:16i |
| load_pulse | output | 3 | One-cycle load command per channel |
| load_val | output | 48 | Last loaded 16-bit value per channel |
| ch_mode | output | 9 | 3-bit mode per channel |
| ch_bcd | output | 3 | Decimal-count flag per channel |
| ch_gate | output | 3 | Power-up gate level per channel |

## Verification
The bench builds the block with its default parameters: three channels and an 8-bit byte lane. With those values the channel field of the control byte has exactly one unused code, 3, and the bench can check that this code is ignored. The 16-bit counts split into two bytes, so every sequencing path is reachable: the low-only, high-only, two-byte and snapshot paths. The bench drives `live_cnt` directly with distinct per-channel values. It changes one of them between a snapshot and its readback, which separates frozen bytes from live ones and shows that one channel's bytes never appear on another.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Byte sequencer position of one channel
  typedef enum logic [2:0] {
    AS_LO  = 3'd0,  // low byte only
    AS_HI  = 3'd1,  // high byte only
    AS_WD0 = 3'd2,  // two-byte access, low byte next
    AS_WD1 = 3'd3,  // two-byte access, high byte next
    AS_LT0 = 3'd4,  // snapshot pending, low byte next
    AS_LT1 = 3'd5   // snapshot pending, high byte next
  } acc_st_t;

  // Access field of a control byte (bits 5:4)
  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_cmd_t;

  function automatic acc_st_t first_state(acc_cmd_t acc);
    case (acc)
      ACC_HI:   first_state = AS_HI;
      ACC_WORD: first_state = AS_WD0;
      default:  first_state = AS_LO;
    endcase
  endfunction

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DW     = 8
) (
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [NUM_CH-1:0] ctrl_sel,
  output logic [NUM_CH-1:0] dat_wr_sel,
  output logic [NUM_CH-1:0] dat_rd_sel,
  output acc_cmd_t          ctrl_acc,
  output logic [2:0]        ctrl_mode,
  output logic              ctrl_bcd
);

  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic       ctrl_wr;
  logic [1:0] ctrl_ch;

  assign ctrl_wr   = bus_wr && (bus_addr == CTRL_ADDR);
  assign ctrl_ch   = bus_wdata[7:6];
  assign ctrl_acc  = acc_cmd_t'(bus_wdata[5:4]);
  assign ctrl_mode = bus_wdata[3:1];
  assign ctrl_bcd  = bus_wdata[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    // a channel code with no channel behind it selects nothing
    assign ctrl_sel[i]   = ctrl_wr && (ctrl_ch == 2'(i));
    assign dat_wr_sel[i] = bus_wr && (bus_addr == 2'(i));
    // write wins over a simultaneous read
    assign dat_rd_sel[i] = bus_rd && !bus_wr && (bus_addr == 2'(i));
  end

endmodule

// File: rtl/tmr_chan_seq.sv
module tmr_chan_seq
  import tmr_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [2:0] MODE_INIT = 3'd3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_sel,
  input  acc_cmd_t        ctrl_acc,
  input  logic [2:0]      ctrl_mode,
  input  logic            ctrl_bcd,
  input  logic            wr_sel,
  input  logic            rd_sel,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] live_cnt,
  output logic [DW-1:0]   rd_byte,
  output logic            ld_pulse,
  output logic [2*DW-1:0] ld_val,
  output logic [2:0]      mode,
  output logic            bcd
);

  localparam int CW = 2 * DW;

  acc_st_t         st_q, st_d;
  acc_cmd_t        base_q, base_d;
  logic [CW-1:0]   snap_q, snap_d;
  logic [DW-1:0]   lo_hold_q, lo_hold_d;
  logic [CW-1:0]   ld_val_q, ld_val_d;
  logic            ld_pulse_q, ld_pulse_d;
  logic [2:0]      mode_q, mode_d;
  logic            bcd_q, bcd_d;
  logic            snapping;

  assign snapping = (st_q == AS_LT0) || (st_q == AS_LT1);

  // next-state logic
  always_comb begin
    st_d       = st_q;
    base_d     = base_q;
    snap_d     = snap_q;
    lo_hold_d  = lo_hold_q;
    ld_val_d   = ld_val_q;
    ld_pulse_d = 1'b0;
    mode_d     = mode_q;
    bcd_d      = bcd_q;
    if (ctrl_sel) begin
      if (ctrl_acc == ACC_SNAP) begin
        snap_d = live_cnt;
        st_d   = AS_LT0;
      end else begin
        mode_d = ctrl_mode;
        bcd_d  = ctrl_bcd;
        base_d = ctrl_acc;
        st_d   = first_state(ctrl_acc);
      end
    end else if (wr_sel) begin
      case (st_q)
        AS_LO: begin
          ld_val_d   = {{DW{1'b0}}, wdata};
          ld_pulse_d = 1'b1;
        end
        AS_HI: begin
          ld_val_d   = {wdata, {DW{1'b0}}};
          ld_pulse_d = 1'b1;
        end
        AS_WD0: begin
          lo_hold_d = wdata;
          st_d      = AS_WD1;
        end
        AS_WD1: begin
          ld_val_d   = {wdata, lo_hold_q};
          ld_pulse_d = 1'b1;
          st_d       = AS_WD0;
        end
        default: ; // snapshot pending: writes dropped
      endcase
    end else if (rd_sel) begin
      case (st_q)
        AS_WD0:  st_d = AS_WD1;
        AS_WD1:  st_d = AS_WD0;
        AS_LT0:  st_d = AS_LT1;
        AS_LT1:  st_d = first_state(base_q);
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= AS_LO;
      base_q     <= ACC_LO;
      snap_q     <= '0;
      lo_hold_q  <= '0;
      ld_val_q   <= '0;
      ld_pulse_q <= 1'b0;
      mode_q     <= MODE_INIT;
      bcd_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      base_q     <= base_d;
      snap_q     <= snap_d;
      lo_hold_q  <= lo_hold_d;
      ld_val_q   <= ld_val_d;
      ld_pulse_q <= ld_pulse_d;
      mode_q     <= mode_d;
      bcd_q      <= bcd_d;
    end
  end

  // read byte selection
  always_comb begin
    case (st_q)
      AS_HI, AS_WD1: rd_byte = live_cnt[CW-1:DW];
      AS_LT0:        rd_byte = snap_q[DW-1:0];
      AS_LT1:        rd_byte = snap_q[CW-1:DW];
      default:       rd_byte = live_cnt[DW-1:0];
    endcase
  end

  assign ld_pulse = ld_pulse_q;
  assign ld_val   = ld_val_q;
  assign mode     = mode_q;
  assign bcd      = bcd_q;

  // R4 R5 R6
  ld_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse_q |-> $past(wr_sel) && !$past(ctrl_sel));

  // R10
  snap_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !ctrl_sel && snapping) |=> !ld_pulse_q && $stable(ld_val_q) && $stable(snap_q));

  // R9
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel && ctrl_acc == ACC_SNAP) |=> (snap_q == $past(live_cnt)) && (st_q == AS_LT0));

  // R3
  ctrl_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel && ctrl_acc != ACC_SNAP) |=> (mode_q == $past(ctrl_mode)) && (bcd_q == $past(ctrl_bcd)));

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int NUM_CH = 3,
  parameter int DW     = 8
) (
  input  logic [1:0]           bus_addr,
  input  logic [NUM_CH*DW-1:0] ch_bytes,
  output logic [DW-1:0]        bus_rdata
);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == 2'(i)) bus_rdata = ch_bytes[i*DW +: DW];
    end
  end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int               NUM_CH    = 3,   // at most 3: address 3 is the control port
  parameter int               DW        = 8,
  parameter logic [2:0]       MODE_INIT = 3'd3,
  parameter logic [NUM_CH-1:0] GATE_INIT = 3'b011
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NUM_CH*2*DW-1:0] live_cnt,
  output logic [NUM_CH-1:0]      load_pulse,
  output logic [NUM_CH*2*DW-1:0] load_val,
  output logic [NUM_CH*3-1:0]    ch_mode,
  output logic [NUM_CH-1:0]      ch_bcd,
  output logic [NUM_CH-1:0]      ch_gate
);

  localparam int CW = 2 * DW;
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic [NUM_CH-1:0]    ctrl_sel, dat_wr_sel, dat_rd_sel;
  acc_cmd_t             ctrl_acc;
  logic [2:0]           ctrl_mode;
  logic                 ctrl_bcd;
  logic [NUM_CH*DW-1:0] ch_bytes;

  tmr_ctrl_decode #(.NUM_CH(NUM_CH), .DW(DW)) u_dec (
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .ctrl_sel   (ctrl_sel),
    .dat_wr_sel (dat_wr_sel),
    .dat_rd_sel (dat_rd_sel),
    .ctrl_acc   (ctrl_acc),
    .ctrl_mode  (ctrl_mode),
    .ctrl_bcd   (ctrl_bcd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan_seq #(.DW(DW), .MODE_INIT(MODE_INIT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_sel  (ctrl_sel[i]),
      .ctrl_acc  (ctrl_acc),
      .ctrl_mode (ctrl_mode),
      .ctrl_bcd  (ctrl_bcd),
      .wr_sel    (dat_wr_sel[i]),
      .rd_sel    (dat_rd_sel[i]),
      .wdata     (bus_wdata),
      .live_cnt  (live_cnt[i*CW +: CW]),
      .rd_byte   (ch_bytes[i*DW +: DW]),
      .ld_pulse  (load_pulse[i]),
      .ld_val    (load_val[i*CW +: CW]),
      .mode      (ch_mode[i*3 +: 3]),
      .bcd       (ch_bcd[i])
    );
  end

  tmr_rd_mux #(.NUM_CH(NUM_CH), .DW(DW)) u_mux (
    .bus_addr  (bus_addr),
    .ch_bytes  (ch_bytes),
    .bus_rdata (bus_rdata)
  );

  assign ch_gate = GATE_INIT;

  // R12
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_ADDR) |-> (bus_rdata == '0));

  // R11
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_pulse));

endmodule

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic [47:0] live_cnt;
  logic [2:0]  load_pulse;
  logic [47:0] load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [2:0]  ch_gate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_host_if u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .live_cnt(live_cnt),
    .load_pulse(load_pulse), .load_val(load_val), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .ch_gate(ch_gate)
  );

  // chk: 0 none, 1 read byte, 2 load on channel addr, 3 no load anywhere
  typedef struct packed {
    logic        rd;
    logic [1:0]  addr;
    logic [7:0]  data;
    logic [1:0]  chk;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 8'h00, 2'd1, 16'h00B2, 4'd8},  // R8 reset access is low only
    '{1'b1, 2'd0, 8'h00, 2'd1, 16'h00B2, 4'd8},
    '{1'b0, 2'd0, 8'h34, 2'd2, 16'h0034, 4'd4},  // R4
    '{1'b0, 2'd3, 8'h20, 2'd3, 16'h0000, 4'd3},  // R3 ch0 high only
    '{1'b1, 2'd0, 8'h00, 2'd1, 16'h00A1, 4'd8},
    '{1'b1, 2'd0, 8'h00, 2'd1, 16'h00A1, 4'd8},
    '{1'b0, 2'd0, 8'h12, 2'd2, 16'h1200, 4'd5},  // R5
    '{1'b0, 2'd3, 8'h76, 2'd3, 16'h0000, 4'd3},  // ch1 word mode 3
    '{1'b0, 2'd1, 8'h78, 2'd3, 16'h0000, 4'd6},  // R6 first byte
    '{1'b0, 2'd1, 8'h56, 2'd2, 16'h5678, 4'd6},
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00D4, 4'd7},  // R7
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00C3, 4'd7},
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00D4, 4'd7},
    '{1'b0, 2'd3, 8'h40, 2'd3, 16'h0000, 4'd9},  // R9 snapshot ch1 (WD1 pending)
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00D4, 4'd9},
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00C3, 4'd9},
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00D4, 4'd9},  // back to word, low first
    '{1'b1, 2'd1, 8'h00, 2'd1, 16'h00C3, 4'd9},
    '{1'b0, 2'd3, 8'hB4, 2'd3, 16'h0000, 4'd11}, // R11 ch2 word mode 2
    '{1'b0, 2'd2, 8'h11, 2'd3, 16'h0000, 4'd11},
    '{1'b0, 2'd1, 8'h99, 2'd3, 16'h0000, 4'd11},
    '{1'b0, 2'd2, 8'h22, 2'd2, 16'h2211, 4'd11},
    '{1'b0, 2'd1, 8'h88, 2'd2, 16'h8899, 4'd11},
    '{1'b0, 2'd3, 8'hC0, 2'd3, 16'h0000, 4'd2},  // R2 channel code 3
    '{1'b1, 2'd0, 8'h00, 2'd1, 16'h00A1, 4'd2},
    '{1'b1, 2'd3, 8'h00, 2'd1, 16'h0000, 4'd12}, // R12 control read
    '{1'b1, 2'd0, 8'h00, 2'd1, 16'h00A1, 4'd12}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic rd, input logic [1:0] a, input logic [7:0] d,
                        output logic [7:0] rv);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = !rd;
    bus_rd    = rd;
    #5 rv = bus_rdata;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    live_cnt = {16'hE5F6, 16'hC3D4, 16'hA1B2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, {7'd0, ch_mode}, 16'h00DB);       // mode 3 on all three
    check(1, {13'd0, ch_bcd}, 16'h0000);
    check(1, {13'd0, ch_gate}, 16'h0003);
    check(1, {13'd0, load_pulse}, 16'h0000);
    check(1, load_val[15:0] | load_val[31:16] | load_val[47:32], 16'h0000);

    for (int i = 0; i < NV; i++) begin
      bus_op(TBL[i].rd, TBL[i].addr, TBL[i].data, rv);
      case (TBL[i].chk)
        2'd1: check(int'(TBL[i].req), {8'h00, rv}, TBL[i].exp);
        2'd2: begin
          check(int'(TBL[i].req), {13'd0, load_pulse}, 16'(3'b001 << TBL[i].addr));
          check(int'(TBL[i].req), load_val[TBL[i].addr*16 +: 16], TBL[i].exp);
        end
        2'd3: check(int'(TBL[i].req), {13'd0, load_pulse}, 16'h0000);
        default: ;
      endcase
    end

    // R11 other channels keep their loads
    check(11, load_val[15:0], 16'h1200);
    check(11, load_val[31:16], 16'h8899);
    check(11, load_val[47:32], 16'h2211);

    // R3 mode and flag outputs
    bus_op(1'b0, 2'd3, 8'h3B, rv);             // ch0 word, mode 5, decimal
    check(3, {13'd0, ch_mode[2:0]}, 16'h0005);
    check(3, {15'd0, ch_bcd[0]}, 16'h0001);

    // R2 control with channel code 3 changes no mode or flag
    bus_op(1'b0, 2'd3, 8'hFF, rv);
    check(2, {7'd0, ch_mode}, {7'd0, 3'd2, 3'd3, 3'd5});
    check(2, {13'd0, ch_bcd}, 16'h0001);

    // R9 snapshot frozen while live count moves
    bus_op(1'b0, 2'd3, 8'h00, rv);
    live_cnt[15:0] = 16'h0F0E;
    bus_op(1'b1, 2'd0, 8'h00, rv); check(9, {8'h00, rv}, 16'h00B2);
    bus_op(1'b1, 2'd0, 8'h00, rv); check(9, {8'h00, rv}, 16'h00A1);
    bus_op(1'b1, 2'd0, 8'h00, rv); check(9, {8'h00, rv}, 16'h000E);
    bus_op(1'b1, 2'd0, 8'h00, rv); check(9, {8'h00, rv}, 16'h000F);

    // R10 writes ignored during snapshot readback
    bus_op(1'b0, 2'd3, 8'h00, rv);
    live_cnt[15:0] = 16'h7766;
    bus_op(1'b0, 2'd0, 8'h55, rv); check(10, {13'd0, load_pulse}, 16'h0000);
    bus_op(1'b1, 2'd0, 8'h00, rv); check(10, {8'h00, rv}, 16'h000E);
    bus_op(1'b0, 2'd0, 8'h66, rv); check(10, {13'd0, load_pulse}, 16'h0000);
    bus_op(1'b1, 2'd0, 8'h00, rv); check(10, {8'h00, rv}, 16'h000F);
    check(10, load_val[15:0], 16'h1200);

    // R6 new control word restarts a half-written pair
    bus_op(1'b0, 2'd3, 8'h30, rv);
    bus_op(1'b0, 2'd0, 8'hAA, rv); check(6, {13'd0, load_pulse}, 16'h0000);
    bus_op(1'b0, 2'd3, 8'h30, rv);
    bus_op(1'b0, 2'd0, 8'hBB, rv); check(6, {13'd0, load_pulse}, 16'h0000);
    bus_op(1'b0, 2'd0, 8'hCC, rv);
    check(6, {13'd0, load_pulse}, 16'h0001);
    check(6, load_val[15:0], 16'hCCBB);

    // R12 write wins over a simultaneous read
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h00; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    bus_op(1'b1, 2'd1, 8'h00, rv); check(12, {8'h00, rv}, 16'h00C3);

    done = 1'b1;
    finish_run();
  end

endmodule